// File: doc/BRIEF.md
# Clocked Multiplexed Address/Data Bus Target

This block is the device-side end of a synchronous parallel host bus. The host drives a clock that never stops. Chip select, a direction line and a set of shared address/data lines change in step with that clock. Every input is sampled on the rising edge of the host clock, so the block has one clock domain and no synchronizers. To the host it looks like a small window of plain storage mapped into its address space: a word read back returns the last word written at that address.

A transfer starts when chip select goes high while the block is idle. That first cycle carries the start address on the low lines of the shared bus, and the direction line chooses read or write for the whole transfer. Each further cycle with chip select high moves one data word. The word pointer advances by one per beat, so single accesses and long bursts use the same sequence. Dropping chip select at any edge ends the transfer at once. During read beats the block drives the shared lines, and its output-enable tells the pad logic when to turn the bus around.

Top module: `srcsync_bus_slave`

## Requirements
- R1: After reset the block is idle, `bus_ad_oe` is low, `bus_ad_out` is zero and every word of the window reads as zero.
- R2: A rising edge at which `bus_cs` is high while the block is idle is an address beat. The start address is taken from `bus_ad_in[AW-1:0]`, and `bus_wr` (1 = write, 0 = read) sampled on that edge fixes the direction. No data moves on that beat.
- R3: In a write transfer, the k-th edge after the address beat at which `bus_cs` is still high (k = 1, 2, ...) stores `bus_ad_in` into the word at start + k - 1. One word moves per clock.
- R4: In a read transfer, during the clock period that follows the address beat, `bus_ad_out` carries the word at the start address. Each later period with `bus_cs` high carries the next word. The host samples the word at the edge that ends the period.
- R5: `bus_ad_oe` is high exactly in read data periods while `bus_cs` is high. It is low during the address beat, during writes and while idle. `bus_ad_out` is zero whenever `bus_ad_oe` is low.
- R6: The mapped window is the DEPTH words starting at BASE (by default addresses 0x20 to 0x2F). Writes outside it are ignored and reads outside it return zero, including the beats of a burst that crosses a window edge.
- R7: An edge with `bus_cs` low ends any transfer immediately. The next edge with `bus_cs` high is again an address beat, even after a single low cycle.
- R8: A read of a window address returns the last word written there.
- R9: Changes of `bus_wr` during data beats are ignored. A read burst stays a read and writes nothing.
- R10: The burst pointer wraps modulo 2^AW, so a burst that runs past the top address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select, high qualifies a transfer |
| bus_wr | input | 1 | Direction at the address beat: 1 write, 0 read |
| bus_ad_in | input | DW | Shared lines as received: address on the first beat, then write data |
| bus_ad_out | output | DW | Read data driven toward the shared lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |

## Verification
The bench writes every address of the 8-bit space in one burst and reads the space back in a burst that wraps. A design that failed to gate writes by the window, or that wrapped the pointer wrongly, would show stray words or misplaced data against the arithmetic model. Short bursts cross each window edge. A chip-select drop is placed mid-burst while the lines hold a value that looks like an in-window address, and the transfer restarts after one low cycle. A design that kept running, or that took the restart word as data, would leave words in the wrong places. The direction line is toggled during a read burst. A design that re-sampled it would corrupt storage or drop the output enable. The output enable and the zeroed output are checked on every cycle of every transfer, so an off-by-one in read latency shows up on the first beat.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_t;

  // Address falls inside the mapped window
  function automatic logic win_hit(input int unsigned a, input int unsigned base,
                                   input int unsigned depth);
    return (a >= base) && (a < base + depth);
  endfunction

  // Word offset of an address inside the window
  function automatic int unsigned win_offset(input int unsigned a, input int unsigned base);
    return a - base;
  endfunction

endpackage

// File: rtl/srb_seq.sv
module srb_seq
  import srb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic [AW-1:0] addr_in,
  output phase_t        phase,
  output logic [AW-1:0] ptr,
  output logic          addr_cap,
  output logic          beat_wr,
  output logic          beat_rd
);

  localparam logic [AW-1:0] STEP = AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ptr   <= '0;
    end else if (!cs) begin
      phase <= PH_IDLE;
    end else if (phase == PH_IDLE) begin
      ptr   <= addr_in;
      phase <= wr ? PH_WR : PH_RD;
    end else begin
      ptr <= ptr + STEP;
    end
  end

  // Named events used by the datapath and the assertions
  assign addr_cap = cs && (phase == PH_IDLE);
  assign beat_wr  = cs && (phase == PH_WR);
  assign beat_rd  = cs && (phase == PH_RD);

  AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> phase == PH_IDLE);                                          // R7
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cap |=> ptr == $past(addr_in));                                // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_wr || beat_rd) |=> ptr == $past(ptr) + STEP);                 // R10
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_wr || beat_rd) |=> phase == $past(phase));                    // R9

endmodule

// File: rtl/srb_store.sv
module srb_store
  import srb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int BASE  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int OW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DW-1:0] mem;
  logic                     hit;
  logic [OW-1:0]            off;

  assign hit = win_hit(32'(addr), BASE, DEPTH);
  assign off = OW'(win_offset(32'(addr), BASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we && hit) begin
      mem[off] <= wdata;
    end
  end

  assign rdata = hit ? mem[off] : '0;

  AST_OOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(mem));                                     // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> mem[$past(off)] == $past(wdata));                   // R3

endmodule

// File: rtl/srcsync_bus_slave.sv
module srcsync_bus_slave
  import srb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int BASE  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_ad_in,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe
);

  phase_t        phase;
  logic [AW-1:0] ptr;
  logic          addr_cap;
  logic          beat_wr;
  logic          beat_rd;
  logic [DW-1:0] rdata;
  logic [DW-AW-1:0] hi_unused;

  assign hi_unused = bus_ad_in[DW-1:AW];

  srb_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (bus_cs),
    .wr       (bus_wr),
    .addr_in  (bus_ad_in[AW-1:0]),
    .phase    (phase),
    .ptr      (ptr),
    .addr_cap (addr_cap),
    .beat_wr  (beat_wr),
    .beat_rd  (beat_rd)
  );

  srb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (beat_wr),
    .addr  (ptr),
    .wdata (bus_ad_in),
    .rdata (rdata)
  );

  assign bus_ad_oe  = beat_rd;
  assign bus_ad_out = beat_rd ? rdata : '0;

  AST_OE_NEEDS_PRIOR_CS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> $past(bus_cs));                                       // R5
  AST_NO_OE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cap |-> !bus_ad_oe);                                           // R5
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ad_oe |-> bus_ad_out == '0);                                   // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (phase == PH_IDLE) && !bus_ad_oe);                       // R1

endmodule

// File: tb/sim_srcsync_bus_slave.sv
module sim_srcsync_bus_slave;

  localparam int AW = 8, DW = 16, DEPTH = 16, BASE = 32, SPACE = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cs = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_ad_in = '0;
  logic [DW-1:0] bus_ad_out;
  logic          bus_ad_oe;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [SPACE];

  always #5 clk = ~clk;

  srcsync_bus_slave #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
  );

  function automatic logic in_win(input int a);
    return a >= BASE && a < BASE + DEPTH;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input int a);
    return in_win(a) ? shadow[a] : '0;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input logic [DW-1:0] s);
    return DW'(a * 257) ^ s;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Address beat; leaves cs high
  task automatic addr_beat(input int a, input logic dir);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = dir; bus_ad_in = DW'(a) | 16'hA500;
    #1 chk("R5 oe low on address beat", DW'(bus_ad_oe), 0);
    @(posedge clk);
  endtask

  task automatic end_xfer();
    @(negedge clk);
    bus_cs = 1'b0; bus_ad_in = DW'(BASE + 1);
    #1 chk("R5 oe low idle", DW'(bus_ad_oe), 0);
    chk("R5 out zero idle", bus_ad_out, 0);
    @(posedge clk);
  endtask

  task automatic wr_burst(input int a, input int n, input logic [DW-1:0] s);
    addr_beat(a, 1'b1);
    for (int k = 0; k < n; k++) begin
      int x = (a + k) % SPACE;
      @(negedge clk);
      bus_ad_in = pat(x, s);
      #1 chk("R5 oe low in write", DW'(bus_ad_oe), 0);
      if (in_win(x)) shadow[x] = pat(x, s);   // R3, R6
      @(posedge clk);
    end
  endtask

  task automatic rd_burst(input int a, input int n, input string tag, input logic flip);
    addr_beat(a, 1'b0);
    for (int k = 0; k < n; k++) begin
      int x = (a + k) % SPACE;
      string t = (a + k >= SPACE) ? "R10" : (!in_win(x) ? "R6" : tag);
      @(negedge clk);
      bus_ad_in = 16'hFFFF;
      if (flip) bus_wr = k[0];   // R9
      #1 chk("R5 oe high in read", DW'(bus_ad_oe), 1);
      chk(t, bus_ad_out, exp_rd(x));
      @(posedge clk);
    end
  endtask

  logic done = 1'b0;

  initial begin
    for (int i = 0; i < SPACE; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 oe after reset", DW'(bus_ad_oe), 0);
    chk("R1 out after reset", bus_ad_out, 0);
    rd_burst(BASE, DEPTH, "R1", 1'b0);
    end_xfer();

    // R3 R6: write the whole address space in one burst, read it back wrapping
    wr_burst(0, SPACE, 16'h5A3C);
    end_xfer();
    rd_burst(0, SPACE + 4, "R8", 1'b0);
    end_xfer();

    // R2 R4: single-word accesses
    wr_burst(BASE + 5, 1, 16'h1111);
    end_xfer();
    rd_burst(BASE + 5, 1, "R4", 1'b0);
    end_xfer();

    // R6: bursts crossing each window edge
    wr_burst(BASE + DEPTH - 2, 5, 16'h0F0F);
    end_xfer();
    wr_burst(BASE - 3, 5, 16'h3C3C);
    end_xfer();
    rd_burst(BASE - 4, DEPTH + 8, "R6", 1'b0);
    end_xfer();

    // R7: drop cs mid-burst while lines look like an in-window address
    wr_burst(BASE + 8, 2, 16'h7777);
    end_xfer();
    wr_burst(BASE + 2, 2, 16'h2222);   // restart after a single low cycle
    end_xfer();
    rd_burst(BASE, DEPTH, "R7", 1'b0);
    end_xfer();

    // R9: direction toggled during a read burst, then verify nothing changed
    rd_burst(BASE, DEPTH, "R9", 1'b1);
    end_xfer();
    rd_burst(BASE, DEPTH, "R9", 1'b0);
    end_xfer();

    // R10: read burst running past the top of the address space
    rd_burst(SPACE - 4, 8, "R10", 1'b0);
    end_xfer();

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule